// File: doc/BRIEF.md
# Configuration Image Byte Loader

This block feeds a configuration image into a target that takes its configuration one byte per write strobe. A pulse on `start_i` begins a load. The block first holds the target in reset for a set number of cycles and waits. It then writes a single zero byte and waits again. After that it opens its byte-stream input.

The first 16 stream bytes form a header. The leading four bytes give the payload length, most significant byte first. The other twelve header bytes are taken in and dropped. Exactly that many payload bytes are then passed straight through to the target, one strobe per accepted byte. Five zero bytes close the image.

One cycle after the last zero byte the block samples the target's error line. If the line is high the load fails. If it is low, the block waits a settle time and reports done. A stream that ends early also ends the load with a failure. This covers a stream that ends inside the header, and one that ends before the declared payload is complete.

Every wait is a parameter counted in clock cycles.

Top module: `cfg_image_loader`

## Requirements
- R1: Reset state. After reset, and until a start is sampled, `tgt_rst_o`, `cfg_wr_o`, `in_ready_o`, `done_o` and `fail_o` are all low.
- R2: Start sequence. A start sampled while idle, done or failed has the following effect, beginning the cycle after the start edge:
  - `tgt_rst_o` is high for RST_CYC cycles.
  - All outputs then stay quiet for HOLD_CYC cycles.
  - `cfg_wr_o` is then high for one cycle with `cfg_data_o` = 0.
  - After PRIME_CYC quiet cycles, `in_ready_o` rises.
- R3: Header. The first HDR_BYTES (16) accepted bytes are the header, and none of them is written. Bytes 0 to 3 form a 32-bit length, byte 0 being the most significant.
- R4: Payload forwarding. While the payload is open:
  - `in_ready_o` is high.
  - In every cycle, `cfg_wr_o` equals `in_valid_i`, and `cfg_data_o` equals `in_data_i`.
  - Exactly the declared number of bytes is forwarded, in stream order.
  - Cycles with `in_valid_i` low write nothing.
- R5: Padding. Straight after the last payload byte, `cfg_wr_o` is high for PAD_BYTES (5) consecutive cycles with data 0, and `in_ready_o` is low.
- R6: Error check. `tgt_err_i` is sampled in the cycle after the last pad byte. If it is high, `fail_o` goes high the next cycle and stays high until the next start.
- R7: Success. If the error line is low at that sample, SETTLE_CYC quiet cycles follow. Then `done_o` goes high and stays high until the next start. `done_o` and `fail_o` are never high together.
- R8: Short header. Either of the following fails the load, with `fail_o` high the cycle after that byte is accepted and nothing written:
  - `in_last_i` is seen on a header byte before byte 15.
  - `in_last_i` is seen on byte 15 while the length is nonzero.
- R9: Truncated payload. `in_last_i` on a payload byte before the declared count is reached sets `fail_o` the next cycle, and no padding is written.
- R10: Start while busy. A start during a load in progress has no effect on the sequence or the result.
- R11: Zero length. A length of 0 sends the block from header byte 15 directly into padding; no stream byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (sampled when not busy) |
| in_valid_i | input | 1 | Stream byte offered |
| in_data_i | input | 8 | Stream byte |
| in_last_i | input | 1 | Offered byte is the final one of the stream |
| in_ready_o | output | 1 | Block takes stream bytes this cycle |
| cfg_data_o | output | 8 | Byte to the configuration port |
| cfg_wr_o | output | 1 | Write strobe to the configuration port |
| tgt_rst_o | output | 1 | Reset pulse to the target |
| tgt_err_i | input | 1 | Error line from the target |
| done_o | output | 1 | Load finished successfully (held) |
| fail_o | output | 1 | Load failed (held) |

## Verification
The outputs have different latencies:
- Payload writes follow the stream in the same cycle: `cfg_wr_o` and `cfg_data_o` are combinational from `in_valid_i` and `in_data_i` while the payload is open.
- The reset pulse, zero bytes, `done_o` and `fail_o` change one cycle after the clock edge at which their cause is sampled. A start edge raises `tgt_rst_o` in the next cycle. A failing byte accepted at an edge shows `fail_o` in the next cycle.

A behavioural model in the bench is stepped at each rising edge from the same sampled inputs. It is compared with every output one nanosecond before the following edge, so same-cycle pass-through and registered results are each checked in the cycle in which they are due. Per-load totals of forwarded bytes, zero bytes and final outcome are checked as well.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  typedef enum logic [3:0] {
    LD_IDLE,
    LD_RESET,
    LD_HOLD,
    LD_PRIME,
    LD_PRIME_WAIT,
    LD_HEADER,
    LD_STREAM,
    LD_PAD,
    LD_CHECK,
    LD_SETTLE,
    LD_DONE,
    LD_FAIL
  } ldr_state_e;

  // States whose length is set by the delay counter
  function automatic logic is_timed(ldr_state_e s);
    return (s == LD_RESET) || (s == LD_HOLD) || (s == LD_PRIME_WAIT) ||
           (s == LD_PAD) || (s == LD_SETTLE);
  endfunction

  // A start is only honoured outside these states
  function automatic logic is_busy(ldr_state_e s);
    return !((s == LD_IDLE) || (s == LD_DONE) || (s == LD_FAIL));
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ldr_downcount.sv
module ldr_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         is_one_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign is_one_o = (cnt_q == W'(1));

endmodule

// File: rtl/ldr_hdr_parse.sv
module ldr_hdr_parse #(
  parameter int HDR_BYTES = 16,
  parameter int LEN_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   take_i,
  input  logic [7:0]             byte_i,
  output logic [8*LEN_BYTES-1:0] len_o,
  output logic                   final_o
);

  localparam int LEN_W = 8 * LEN_BYTES;
  localparam int IDX_W = $clog2(HDR_BYTES);

  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;

  // Big-endian accumulation: each new byte enters at the low end
  function automatic logic [LEN_W-1:0] push_be(logic [LEN_W-1:0] acc, logic [7:0] b);
    return {acc[LEN_W-9:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      len_q <= '0;
    end else if (clear_i) begin
      idx_q <= '0;
      len_q <= '0;
    end else if (take_i) begin
      if (!final_o) idx_q <= idx_q + 1'b1;
      if (idx_q < IDX_W'(LEN_BYTES)) len_q <= push_be(len_q, byte_i);
    end
  end

  assign final_o = (idx_q == IDX_W'(HDR_BYTES - 1));
  assign len_o   = len_q;

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter int RST_CYC    = 4,
  parameter int HOLD_CYC   = 6,
  parameter int PRIME_CYC  = 5,
  parameter int SETTLE_CYC = 7,
  parameter int PAD_BYTES  = 5,
  parameter int HDR_BYTES  = 16,
  parameter int LEN_BYTES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       in_last_i,
  output logic       in_ready_o,
  output logic [7:0] cfg_data_o,
  output logic       cfg_wr_o,
  output logic       tgt_rst_o,
  input  logic       tgt_err_i,
  output logic       done_o,
  output logic       fail_o
);
  import ldr_pkg::*;

  localparam int LEN_W   = 8 * LEN_BYTES;
  localparam int DLY_MAX = max2(max2(max2(RST_CYC, HOLD_CYC), max2(PRIME_CYC, SETTLE_CYC)), PAD_BYTES);
  localparam int DLY_W   = $clog2(DLY_MAX + 1);

  ldr_state_e st_q, st_n;

  // Named internal events
  logic             start_acc;
  logic             hdr_phase;
  logic             pay_phase;
  logic             chk_phase;
  logic             busy_w;
  logic             hs_hdr;
  logic             hs_pay;
  logic             hdr_final;
  logic             pay_one;
  logic             dly_one;
  logic             dly_load;
  logic [DLY_W-1:0] dly_val;
  logic             pay_load;
  logic [LEN_W-1:0] hdr_len;

  function automatic logic [DLY_W-1:0] delay_of(ldr_state_e s);
    case (s)
      LD_RESET:      return DLY_W'(RST_CYC);
      LD_HOLD:       return DLY_W'(HOLD_CYC);
      LD_PRIME_WAIT: return DLY_W'(PRIME_CYC);
      LD_PAD:        return DLY_W'(PAD_BYTES);
      LD_SETTLE:     return DLY_W'(SETTLE_CYC);
      default:       return DLY_W'(1);
    endcase
  endfunction

  assign busy_w    = is_busy(st_q);
  assign start_acc = start_i && !busy_w;
  assign hdr_phase = (st_q == LD_HEADER);
  assign pay_phase = (st_q == LD_STREAM);
  assign chk_phase = (st_q == LD_CHECK);
  assign hs_hdr    = hdr_phase && in_valid_i;
  assign hs_pay    = pay_phase && in_valid_i;

  always_comb begin
    st_n = st_q;
    case (st_q)
      LD_IDLE, LD_DONE, LD_FAIL: if (start_i) st_n = LD_RESET;
      LD_RESET:      if (dly_one) st_n = LD_HOLD;
      LD_HOLD:       if (dly_one) st_n = LD_PRIME;
      LD_PRIME:      st_n = LD_PRIME_WAIT;
      LD_PRIME_WAIT: if (dly_one) st_n = LD_HEADER;
      LD_HEADER: begin
        if (hs_hdr) begin
          if (!hdr_final) begin
            if (in_last_i) st_n = LD_FAIL;
          end else if (hdr_len == '0) begin
            st_n = LD_PAD;
          end else if (in_last_i) begin
            st_n = LD_FAIL;
          end else begin
            st_n = LD_STREAM;
          end
        end
      end
      LD_STREAM: begin
        if (hs_pay) begin
          if (pay_one)        st_n = LD_PAD;
          else if (in_last_i) st_n = LD_FAIL;
        end
      end
      LD_PAD:    if (dly_one) st_n = LD_CHECK;
      LD_CHECK:  st_n = tgt_err_i ? LD_FAIL : LD_SETTLE;
      LD_SETTLE: if (dly_one) st_n = LD_DONE;
      default:   st_n = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LD_IDLE;
    else        st_q <= st_n;
  end

  assign dly_load = (st_n != st_q) && is_timed(st_n);
  assign dly_val  = delay_of(st_n);
  assign pay_load = hdr_phase && (st_n == LD_STREAM);

  ldr_downcount #(.W(DLY_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (dly_load),
    .val_i    (dly_val),
    .dec_i    (is_timed(st_q)),
    .is_one_o (dly_one)
  );

  ldr_downcount #(.W(LEN_W)) u_remain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (pay_load),
    .val_i    (hdr_len),
    .dec_i    (hs_pay),
    .is_one_o (pay_one)
  );

  ldr_hdr_parse #(.HDR_BYTES(HDR_BYTES), .LEN_BYTES(LEN_BYTES)) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc),
    .take_i  (hs_hdr),
    .byte_i  (in_data_i),
    .len_o   (hdr_len),
    .final_o (hdr_final)
  );

  assign in_ready_o = hdr_phase || pay_phase;
  assign cfg_wr_o   = (st_q == LD_PRIME) || (st_q == LD_PAD) || hs_pay;
  assign cfg_data_o = hs_pay ? in_data_i : 8'h00;
  assign tgt_rst_o  = (st_q == LD_RESET);
  assign done_o     = (st_q == LD_DONE);
  assign fail_o     = (st_q == LD_FAIL);

endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       in_valid_i,
  input logic [7:0] in_data_i,
  input logic       in_last_i,
  input logic       in_ready_o,
  input logic [7:0] cfg_data_o,
  input logic       cfg_wr_o,
  input logic       tgt_rst_o,
  input logic       tgt_err_i,
  input logic       done_o,
  input logic       fail_o,
  input logic       busy,
  input logic       in_hdr,
  input logic       in_chk,
  input logic       hs_pay,
  input logic       pay_final
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst_o |-> (!cfg_wr_o && !in_ready_o)); // R2

  AST_HEADER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_hdr |-> !cfg_wr_o); // R3

  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_pay |-> (cfg_wr_o && (cfg_data_o == in_data_i))); // R4

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_o && !in_ready_o) |-> (cfg_data_o == 8'h00)); // R5

  AST_ERR_TO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_chk && tgt_err_i) |=> fail_o); // R6

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> fail_o); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R7

  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o)); // R7

  AST_TRUNC_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_pay && in_last_i && !pay_final) |=> fail_o); // R9

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> !$rose(tgt_rst_o)); // R10

endmodule

bind cfg_image_loader cfg_image_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .in_last_i  (in_last_i),
  .in_ready_o (in_ready_o),
  .cfg_data_o (cfg_data_o),
  .cfg_wr_o   (cfg_wr_o),
  .tgt_rst_o  (tgt_rst_o),
  .tgt_err_i  (tgt_err_i),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .busy       (busy_w),
  .in_hdr     (hdr_phase),
  .in_chk     (chk_phase),
  .hs_pay     (hs_pay),
  .pay_final  (pay_one)
);

// File: tb/tb_cfg_image_loader.sv
`timescale 1ns/1ps
module tb_cfg_image_loader;

  localparam int RST    = 4;
  localparam int HOLD   = 6;
  localparam int PRIME  = 5;
  localparam int SETTLE = 7;
  localparam int PAD    = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_r = 1'b0;
  logic       valid_r = 1'b0;
  logic [7:0] data_r = 8'h00;
  logic       last_r = 1'b0;
  logic       err_r = 1'b0;
  logic       in_ready_o, cfg_wr_o, tgt_rst_o, done_o, fail_o;
  logic [7:0] cfg_data_o;

  always #2.5 clk = ~clk;

  cfg_image_loader #(
    .RST_CYC(RST), .HOLD_CYC(HOLD), .PRIME_CYC(PRIME),
    .SETTLE_CYC(SETTLE), .PAD_BYTES(PAD), .HDR_BYTES(16), .LEN_BYTES(4)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_r), .in_valid_i(valid_r),
    .in_data_i(data_r), .in_last_i(last_r), .in_ready_o(in_ready_o),
    .cfg_data_o(cfg_data_o), .cfg_wr_o(cfg_wr_o), .tgt_rst_o(tgt_rst_o),
    .tgt_err_i(err_r), .done_o(done_o), .fail_o(fail_o)
  );

  int total = 0;
  int bad = 0;
  int cyc_all = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: phase codes 0 idle,1 reset,2 hold,3 prime,4 prime wait,
  // 5 header,6 payload,7 pad,8 error sample,9 settle,10 done,11 failed
  int          m_ph = 0;
  int          m_n = 0;
  int          m_hb = 0;
  longint      m_got = 0;
  logic [31:0] m_len = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0;
    end else begin
      case (m_ph)
        0, 10, 11: if (start_r) begin m_ph = 1; m_n = 0; end
        1: begin m_n++; if (m_n == RST) begin m_ph = 2; m_n = 0; end end
        2: begin m_n++; if (m_n == HOLD) m_ph = 3; end
        3: begin m_ph = 4; m_n = 0; end
        4: begin m_n++; if (m_n == PRIME) begin m_ph = 5; m_hb = 0; m_len = '0; end end
        5: if (valid_r) begin
             if (m_hb < 4) m_len = {m_len[23:0], data_r};
             if (m_hb == 15) begin
               if (m_len == 0) begin m_ph = 7; m_n = 0; end
               else if (last_r) m_ph = 11;
               else begin m_ph = 6; m_got = 0; end
             end else if (last_r) m_ph = 11;
             m_hb++;
           end
        6: if (valid_r) begin
             m_got++;
             if (m_got == longint'(m_len)) begin m_ph = 7; m_n = 0; end
             else if (last_r) m_ph = 11;
           end
        7: begin m_n++; if (m_n == PAD) m_ph = 8; end
        8: begin m_ph = err_r ? 11 : 9; m_n = 0; end
        9: begin m_n++; if (m_n == SETTLE) m_ph = 10; end
        default: m_ph = 0;
      endcase
    end
  end

  // Per-cycle comparison and write monitor, 1 ns before the rising edge
  byte unsigned pay_seen[$];
  int zero_seen = 0;

  always @(negedge clk) begin
    logic e_wr;
    #1.5;
    e_wr = (m_ph == 3) || (m_ph == 7) || ((m_ph == 6) && valid_r);
    chk("R2", "tgt_rst_o", tgt_rst_o, m_ph == 1);
    chk("R3", "in_ready_o", in_ready_o, (m_ph == 5) || (m_ph == 6));
    chk("R4", "cfg_wr_o", cfg_wr_o, e_wr);
    if (e_wr) chk("R4", "cfg_data_o", cfg_data_o, (m_ph == 6) ? data_r : 8'h00);
    chk("R7", "done_o", done_o, m_ph == 10);
    chk("R6", "fail_o", fail_o, m_ph == 11);
    if (cfg_wr_o) begin
      if (in_ready_o) pay_seen.push_back(cfg_data_o);
      else if (cfg_data_o == 8'h00) zero_seen++;
    end
  end

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc_all);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_case(input string req, input logic [31:0] len_field, input int stream_len,
                          input bit err, input bit gaps, input int poke_at,
                          input bit exp_done, input int exp_pay, input int exp_zero);
    byte unsigned q[$];
    byte unsigned exp_bytes[$];
    int cyc = 0;
    int mism = 0;
    for (int i = 0; i < stream_len; i++) begin
      byte unsigned b;
      if (i < 4)       b = byte'(len_field >> (8 * (3 - i)));
      else if (i < 16) b = byte'(8'h30 + i);
      else             b = byte'(((i - 16) * 7 + 11) & 8'hFF);
      q.push_back(b);
      if (i >= 16 && exp_bytes.size() < exp_pay) exp_bytes.push_back(b);
    end
    pay_seen.delete();
    zero_seen = 0;
    @(negedge clk);
    err_r = err;
    start_r = 1'b1;
    @(negedge clk);
    start_r = 1'b0;
    while (cyc < 5000) begin
      if (cyc > 0) @(negedge clk);
      if (q.size() > 0 && !(gaps && (cyc % 3 == 1))) begin
        valid_r = 1'b1; data_r = q[0]; last_r = (q.size() == 1);
      end else begin
        valid_r = 1'b0; last_r = 1'b0;
      end
      start_r = (poke_at == cyc);
      #1.5;
      if (valid_r && in_ready_o) void'(q.pop_front());
      cyc++;
      if (done_o || fail_o) break;
    end
    @(negedge clk);
    valid_r = 1'b0; last_r = 1'b0; start_r = 1'b0;
    chk(req, "load finished", cyc < 5000, 1);
    chk(req, "done_o at end", done_o, exp_done);
    chk(req, "fail_o at end", fail_o, !exp_done);
    chk(req, "payload bytes written", pay_seen.size(), exp_pay);
    for (int k = 0; k < exp_bytes.size() && k < pay_seen.size(); k++)
      if (pay_seen[k] != exp_bytes[k]) mism++;
    chk(req, "payload content mismatches", mism, 0);
    chk("R5", "zero bytes written", zero_seen, exp_zero);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1.5;
    // R1: quiet outputs during and after reset
    chk("R1", "tgt_rst_o in reset", tgt_rst_o, 0);
    chk("R1", "done_o in reset", done_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1.5;
    chk("R1", "in_ready_o idle", in_ready_o, 0);
    chk("R1", "cfg_wr_o idle", cfg_wr_o, 0);
    chk("R1", "fail_o idle", fail_o, 0);

    // R2 R4 R5 R7: plain load, 3 payload bytes, 1 prime + 5 pad zeros
    run_case("R7", 32'd3, 19, 1'b0, 1'b0, -1, 1'b1, 3, 1 + PAD);
    // R4 R10: gaps in the stream and a start pulse while busy
    run_case("R10", 32'd6, 22, 1'b0, 1'b1, 30, 1'b1, 6, 1 + PAD);
    // R3: big-endian length 0x0102 = 258 bytes
    run_case("R3", 32'h0000_0102, 16 + 258, 1'b0, 1'b0, -1, 1'b1, 258, 1 + PAD);
    // R11: zero length goes straight to padding; extra bytes are not taken
    run_case("R11", 32'd0, 20, 1'b0, 1'b0, -1, 1'b1, 0, 1 + PAD);
    // R6: error line high at the sample
    run_case("R6", 32'd4, 20, 1'b1, 1'b0, -1, 1'b0, 4, 1 + PAD);
    // R8: stream ends inside the header
    run_case("R8", 32'd4, 10, 1'b0, 1'b0, -1, 1'b0, 0, 1);
    // R8: stream ends at header byte 15 with nonzero length
    run_case("R8", 32'd2, 16, 1'b0, 1'b0, -1, 1'b0, 0, 1);
    // R9: payload cut short after 2 of 5 bytes
    run_case("R9", 32'd5, 18, 1'b0, 1'b1, -1, 1'b0, 2, 1);
    // R7: a fresh load from the failed state succeeds
    run_case("R7", 32'd1, 17, 1'b0, 1'b0, -1, 1'b1, 1, 1 + PAD);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule